// File: doc/BRIEF.md
# Interrupt Mask and Return Unit

This unit sits beside the sequencer of a small 16-bit processor that has a parameterised number of interrupt priority levels (two by default, level 1 above level 0). It holds a hidden mask flag and a short stack of the levels being serviced. From these it decides, each cycle, whether a pending request may be taken. The sequencer answers an accepted request with a one-cycle acknowledge. That acknowledge records the level and raises the mask, so the save sequence at the start of a handler cannot be interrupted.

Inside a handler, firmware uses two dedicated instructions to lower or raise the mask. Lowering it lets a request of a higher level pre-empt the handler. Raising it again protects the state-restore sequence. Each of these instructions runs for a fixed number of cycles, and its effect on the mask lands when it finishes. A return instruction computes its target from the word popped off the return stack and a 6-bit displacement. When its level-pop bit is set, it also drops the mask and removes the current level, which makes the interrupted level active again.

Top module: `imr_unit`

## Requirements
- R1: After reset, mask_flag, cur_valid, ret_valid, seq_busy and irq_accept are all 0.
- R2: An ack pulse sets mask_flag on the next cycle and makes cur_level equal the level given by acc_level in the ack cycle, with cur_valid 1.
- R3: While mask_flag is 1, irq_accept is 0 whatever irq_req holds.
- R4: With mask_flag 0, irq_accept is 1 exactly when some request is pending and its highest pending index is above cur_level, or no level is active. acc_level gives that highest pending index. A request at or below the active level is never taken.
- R5: A clear-mask strobe (mask_clr) or set-mask strobe (mask_set) raises seq_busy for exactly INSN_CYCLES cycles, 9 by default. mask_flag takes the new value (0 for clear, 1 for set) on the clock edge where seq_busy falls.
- R6: A return strobe with ret_pop 1 makes mask_flag 0 on the next cycle and removes the top level, so cur_level shows the level that was interrupted, or cur_valid becomes 0.
- R7: A return strobe with ret_pop 0 leaves mask_flag, cur_valid and cur_level unchanged.
- R8: One cycle after a return strobe, ret_valid is 1 for one cycle and ret_addr = (pop_word + ret_ofs − 32·ret_back) mod 2^16. Here ret_ofs is the 5-bit offset and ret_back is the displacement sign bit.
- R9: A pre-emption leaves the level stack holding both levels. A later popping return brings back the lower level.
- R10: A popping return with no level active leaves cur_valid 0 and still clears mask_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_LVLS | Request per level, higher index is higher priority |
| ack | input | 1 | Acknowledge of the currently accepted request |
| mask_clr | input | 1 | Clear-mask instruction strobe |
| mask_set | input | 1 | Set-mask instruction strobe |
| ret_strobe | input | 1 | Return instruction strobe |
| ret_pop | input | 1 | Return also pops the level and clears the mask |
| ret_back | input | 1 | Displacement sign bit (subtracts 32) |
| ret_ofs | input | OFS_W | Unsigned part of the displacement |
| pop_word | input | ADDR_W | Word popped from the return stack |
| irq_accept | output | 1 | A pending request may be acknowledged |
| acc_level | output | LVL_W | Level that would be acknowledged |
| mask_flag | output | 1 | Hidden interrupt mask |
| cur_valid | output | 1 | Some level is being serviced |
| cur_level | output | LVL_W | Level being serviced |
| ret_addr | output | ADDR_W | Computed return target |
| ret_valid | output | 1 | ret_addr is valid this cycle |
| seq_busy | output | 1 | A mask instruction is in progress |

## Verification
The checker assumes the sequencer only acknowledges while irq_accept is high. It also assumes no two of ack, a mask strobe and a return strobe arrive in the same cycle, and that no strobe arrives while seq_busy is high. The stimulus issues one strobe at a time and lets each mask instruction finish before the next action. Every acknowledge it issues is preceded by a cycle in which the reference model predicts acceptance. Overflowing the level stack takes more nested acknowledges than the acceptance rule allows, so the stimulus never attempts it.

// File: rtl/imr_pkg.sv
package imr_pkg;
   typedef enum logic [1:0] {
      MOP_NONE = 2'd0,
      MOP_CLR  = 2'd1,
      MOP_SET  = 2'd2
   } mask_op_e;
endpackage

// File: rtl/imr_lvl_stack.sv
module imr_lvl_stack #(
   parameter int NUM_LVLS = 2,
   parameter int DEPTH    = NUM_LVLS + 1,
   parameter int LVL_W    = (NUM_LVLS > 1) ? $clog2(NUM_LVLS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [LVL_W-1:0] push_lvl,
   output logic             top_valid,
   output logic [LVL_W-1:0] top_lvl
);
   localparam int CODE_W = $clog2(NUM_LVLS + 1);

   logic [CODE_W-1:0] ent [DEPTH];
   logic [CODE_W-1:0] up  [DEPTH];
   logic [CODE_W-1:0] dn  [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("imr_lvl_stack: DEPTH must be at least 2");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      if (g == 0) begin : g_head
         assign up[g] = CODE_W'(push_lvl) + CODE_W'(1);
      end else begin : g_body
         assign up[g] = ent[g-1];
      end
      if (g == DEPTH - 1) begin : g_tail
         assign dn[g] = '0;
      end else begin : g_mid
         assign dn[g] = ent[g+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ent[g] <= '0;
         else if (push) ent[g] <= up[g];
         else if (pop)  ent[g] <= dn[g];
      end
   end

   assign top_valid = (ent[0] != '0);
   assign top_lvl   = LVL_W'(ent[0] - CODE_W'(1));
endmodule

// File: rtl/imr_mask_seq.sv
module imr_mask_seq
   import imr_pkg::*;
#(
   parameter int INSN_CYCLES = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mask_clr,
   input  logic mask_set,
   input  logic ack,
   input  logic ret_clear,
   output logic mask,
   output logic busy
);
   localparam int CNT_W = $clog2(INSN_CYCLES + 1);

   if (INSN_CYCLES < 1) begin : g_bad_cycles
      $error("imr_mask_seq: INSN_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   mask_op_e         op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         op  <= MOP_NONE;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end else if (mask_clr || mask_set) begin
         cnt <= CNT_W'(INSN_CYCLES);
         op  <= mask_set ? MOP_SET : MOP_CLR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask <= 1'b0;
      else if (cnt == CNT_W'(1))   mask <= (op == MOP_SET);
      else if (ack)                mask <= 1'b1;
      else if (ret_clear)          mask <= 1'b0;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/imr_ret_calc.sv
module imr_ret_calc #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_strobe,
   input  logic              ret_back,
   input  logic [OFS_W-1:0]  ret_ofs,
   input  logic [ADDR_W-1:0] pop_word,
   output logic [ADDR_W-1:0] ret_addr,
   output logic              ret_valid
);
   localparam int EXT_W = ADDR_W - OFS_W - 1;

   if (EXT_W < 1) begin : g_bad_width
      $error("imr_ret_calc: ADDR_W must exceed OFS_W + 1");
   end

   logic [ADDR_W-1:0] disp;
   assign disp = {{EXT_W{ret_back}}, ret_back, ret_ofs};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_valid <= 1'b0;
         ret_addr  <= '0;
      end else begin
         ret_valid <= ret_strobe;
         if (ret_strobe) ret_addr <= pop_word + disp;
      end
   end
endmodule

// File: rtl/imr_unit.sv
module imr_unit #(
   parameter int NUM_LVLS    = 2,
   parameter int ADDR_W      = 16,
   parameter int OFS_W       = 5,
   parameter int INSN_CYCLES = 9,
   parameter int LVL_W       = (NUM_LVLS > 1) ? $clog2(NUM_LVLS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LVLS-1:0] irq_req,
   input  logic                ack,
   input  logic                mask_clr,
   input  logic                mask_set,
   input  logic                ret_strobe,
   input  logic                ret_pop,
   input  logic                ret_back,
   input  logic [OFS_W-1:0]    ret_ofs,
   input  logic [ADDR_W-1:0]   pop_word,
   output logic                irq_accept,
   output logic [LVL_W-1:0]    acc_level,
   output logic                mask_flag,
   output logic                cur_valid,
   output logic [LVL_W-1:0]    cur_level,
   output logic [ADDR_W-1:0]   ret_addr,
   output logic                ret_valid,
   output logic                seq_busy
);
   localparam int DEPTH = NUM_LVLS + 1;

   if (NUM_LVLS < 1) begin : g_bad_lvls
      $error("imr_unit: NUM_LVLS must be at least 1");
   end

   logic             pend_any;
   logic [LVL_W-1:0] pend_hi;

   always_comb begin
      pend_any = 1'b0;
      pend_hi  = '0;
      for (int i = 0; i < NUM_LVLS; i++) begin
         if (irq_req[i]) begin
            pend_any = 1'b1;
            pend_hi  = LVL_W'(i);
         end
      end
   end

   assign acc_level  = pend_hi;
   assign irq_accept = !mask_flag && pend_any && (!cur_valid || (pend_hi > cur_level));

   logic ret_clear;
   assign ret_clear = ret_strobe && ret_pop;

   imr_lvl_stack #(.NUM_LVLS(NUM_LVLS), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ack),
      .pop       (ret_clear),
      .push_lvl  (pend_hi),
      .top_valid (cur_valid),
      .top_lvl   (cur_level)
   );

   imr_mask_seq #(.INSN_CYCLES(INSN_CYCLES)) u_mseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mask_clr  (mask_clr),
      .mask_set  (mask_set),
      .ack       (ack),
      .ret_clear (ret_clear),
      .mask      (mask_flag),
      .busy      (seq_busy)
   );

   imr_ret_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ret (
      .clk        (clk),
      .rst_n      (rst_n),
      .ret_strobe (ret_strobe),
      .ret_back   (ret_back),
      .ret_ofs    (ret_ofs),
      .pop_word   (pop_word),
      .ret_addr   (ret_addr),
      .ret_valid  (ret_valid)
   );
endmodule

// File: rtl/imr_unit_chk.sv
module imr_unit_chk #(
   parameter int LVL_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             mask_clr,
   input logic             mask_set,
   input logic             ret_strobe,
   input logic             ret_pop,
   input logic             irq_accept,
   input logic [LVL_W-1:0] acc_level,
   input logic             mask_flag,
   input logic             cur_valid,
   input logic [LVL_W-1:0] cur_level,
   input logic             ret_valid,
   input logic             seq_busy
);
   p_ack_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> irq_accept);

   p_ack_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (mask_flag && cur_valid && cur_level == $past(acc_level)));

   p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mask_flag |-> !irq_accept);

   p_level_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_accept && cur_valid) |-> (acc_level > cur_level));

   p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> $past(mask_clr || mask_set));

   p_pop_unmasks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_strobe && ret_pop && !seq_busy) |=> !mask_flag);

   p_keep_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_strobe && !ret_pop && !seq_busy) |=> ($stable(mask_flag) && $stable(cur_valid)));

   p_ret_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_strobe |=> ret_valid);
endmodule

bind imr_unit imr_unit_chk #(.LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ack        (ack),
   .mask_clr   (mask_clr),
   .mask_set   (mask_set),
   .ret_strobe (ret_strobe),
   .ret_pop    (ret_pop),
   .irq_accept (irq_accept),
   .acc_level  (acc_level),
   .mask_flag  (mask_flag),
   .cur_valid  (cur_valid),
   .cur_level  (cur_level),
   .ret_valid  (ret_valid),
   .seq_busy   (seq_busy)
);

// File: tb/tb_imr_unit.sv
module tb_imr_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_req = '0;
   logic          ack = 1'b0, mask_clr = 1'b0, mask_set = 1'b0;
   logic          ret_strobe = 1'b0, ret_pop = 1'b0, ret_back = 1'b0;
   logic [4:0]    ret_ofs = '0;
   logic [15:0]   pop_word = '0;
   logic          irq_accept, mask_flag, cur_valid, ret_valid, seq_busy;
   logic [0:0]    acc_level, cur_level;
   logic [15:0]   ret_addr;

   imr_unit dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack(ack),
      .mask_clr(mask_clr), .mask_set(mask_set), .ret_strobe(ret_strobe),
      .ret_pop(ret_pop), .ret_back(ret_back), .ret_ofs(ret_ofs),
      .pop_word(pop_word), .irq_accept(irq_accept), .acc_level(acc_level),
      .mask_flag(mask_flag), .cur_valid(cur_valid), .cur_level(cur_level),
      .ret_addr(ret_addr), .ret_valid(ret_valid), .seq_busy(seq_busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model
   int m_mask = 0, m_cnt = 0, m_op = 0, m_retv = 0, m_reta = 0;
   int m_stk[$];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pend_hi();
      int h = -1;
      for (int i = 0; i < NL; i++) if (irq_req[i]) h = i;
      return h;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = 0; m_cnt = 0; m_retv = 0; m_stk.delete();
      end else begin
         m_retv = 0;
         if (m_cnt != 0) begin
            if (m_cnt == 1) m_mask = m_op;
            m_cnt--;
         end else if (mask_clr || mask_set) begin
            m_cnt = 9;
            m_op  = mask_set ? 1 : 0;
         end
         if (ack) begin
            m_stk.push_front(pend_hi());
            m_mask = 1;
         end
         if (ret_strobe) begin
            m_retv = 1;
            m_reta = (int'(pop_word) + int'(ret_ofs) - (ret_back ? 32 : 0)) & 16'hFFFF;
            if (ret_pop) begin
               m_mask = 0;
               if (m_stk.size() != 0) void'(m_stk.pop_front());
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int h, cur, acc;
         h   = pend_hi();
         cur = (m_stk.size() != 0) ? m_stk[0] : -1;
         acc = (m_mask == 0 && h >= 0 && h > cur) ? 1 : 0;
         chk("R3/R4 irq_accept", int'(irq_accept), acc);
         if (acc != 0) chk("R4 acc_level", int'(acc_level), h);
         chk("R2/R5/R6/R7/R10 mask_flag", int'(mask_flag), m_mask);
         chk("R5 seq_busy", int'(seq_busy), (m_cnt != 0) ? 1 : 0);
         chk("R2/R6/R7/R9/R10 cur_valid", int'(cur_valid), (cur >= 0) ? 1 : 0);
         if (cur >= 0) chk("R2/R6/R9 cur_level", int'(cur_level), cur);
         chk("R8 ret_valid", int'(ret_valid), m_retv);
         if (m_retv != 0) chk("R8 ret_addr", int'(ret_addr), m_reta);
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin
         @(posedge clk); #1;
         ack = 0; mask_clr = 0; mask_set = 0; ret_strobe = 0;
      end
   endtask

   task automatic do_ret(bit pop, bit back, logic [4:0] ofs, logic [15:0] w);
      ret_strobe = 1; ret_pop = pop; ret_back = back; ret_ofs = ofs; pop_word = w;
      tick(2);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1 mask_flag", int'(mask_flag), 0);
      chk("R1 cur_valid", int'(cur_valid), 0);
      chk("R1 ret_valid", int'(ret_valid), 0);
      chk("R1 seq_busy", int'(seq_busy), 0);
      chk("R1 irq_accept", int'(irq_accept), 0);
      tick();
      // R4 low request accepted, R2 ack masks and records level 0
      irq_req = 2'b01; tick();
      ack = 1; tick();
      // R3 high request held off while masked
      irq_req = 2'b11; tick(3);
      // R5 clear-mask, then R4/R9 high pre-empts low
      mask_clr = 1; tick(11);
      ack = 1; tick();
      // R4 same/lower requests blocked with mask clear
      mask_clr = 1; tick(11);
      irq_req = 2'b01; tick(2);
      irq_req = 2'b10; tick(2);
      // R6/R9 popping return exposes level 0, R8 target
      irq_req = 2'b00;
      do_ret(1, 0, 5'd5, 16'h1234);
      // R5 set-mask, R7/R8 non-popping return with backward wrap
      mask_set = 1; tick(11);
      do_ret(0, 1, 5'd3, 16'h0010);
      do_ret(0, 0, 5'd31, 16'hFFF0);
      // R6 pop to empty, R10 pop on empty
      do_ret(1, 1, 5'd0, 16'h8000);
      do_ret(1, 0, 5'd1, 16'h0000);
      // R4 low request accepted again
      irq_req = 2'b01; tick(2);
      ack = 1; tick(2);
      irq_req = 2'b00; tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule